// File: doc/BRIEF.md
# Network Controller Indirect Register File

This block is the host-facing register file of a network controller. A host reaches it through two 16-bit ports that share one data bus. The address port takes a register number. The data port then reads or writes the register that number selects. The selected number stays put, so any number of data accesses can follow a single address write.

Register 0 is the mode and status word. Its bits fall into three groups. Command bits are set when the host writes a 1 to them. Event flags are raised by the ring engines and cleared when the host writes a 1 to them. Activity bits and summary bits can only be read.

The other registers hold configuration: the init block address, a byte-order control word, a 64-bit multicast filter and a promiscuous flag. They can be written only while the controller is stopped. The block drives a gated interrupt line and one-cycle init, start, stop and transmit-demand strobes for the engines.

Top module: `netcsr_regs`

## Requirements
- R1: After reset, register 0 reads 0x0004 (bit 2, the stop bit, set), every other register reads 0, the address port reads 0 and all strobes and the interrupt are low.
- R2: The address port keeps its value until the host writes that port again, and it reads back its value. Consecutive data accesses all reach the same register.
- R3: A write to register 0 with bit 2 set enters the stop state. This takes priority over bit 0 (init) and bit 1 (start) in the same write, so writing 0x0005 while stopped reads back 0x0004. No init strobe follows.
- R4: Writing 1 to bit 0 (init) or bit 1 (start) of register 0 sets that bit and leaves the stop state. Writing 1 to bit 3 (demand) sets it while not stopped. Writing 0 to any of these bits leaves it unchanged. Each accepted 1 produces a strobe that is high for exactly the cycle after the write. Demand clears when a transmit-done event is accepted.
- R5: Bit 4 reads as the transmit-active input and bit 5 as the receive-active input, both only while the start bit is set. Writes to bits 4, 5 and 7 have no effect.
- R6: Bits 8 to 14 of register 0 are event flags: 8 init done, 9 transmit done, 10 receive done, 11 memory error, 12 missed frame, 13 carrier error, 14 babble. A flag is set by its event input and cleared by writing 1 to its bit. Writing 0 leaves it unchanged.
- R7: Bit 15 reads as the OR of bits 11 to 14. Writing bit 15 has no effect.
- R8: Bit 7 reads as the OR of bits 8, 9, 10, 11, 12 and 14. The interrupt output equals bit 7 AND bit 6. Bit 6 is a plain read/write enable.
- R9: When an event input and a host write clearing the same flag fall in the same cycle, the flag ends up set.
- R10: Entering the stop state clears the init, start and demand bits and all event flags. While stopped, event inputs are ignored.
- R11: Writes to registers other than 0 take effect only while the stop bit is set. At other times they leave the register contents and the outputs unchanged.
- R12: Entering the stop state returns register 3 to 0, which is the little-endian default.
- R13: Register 1 holds the low 16 bits of the init block address. Register 2 holds the upper 8 bits in its bits 7..0. Register 3 holds byte-control bits 2..0. Registers 8 to 11 hold the filter words, with register 8 holding the filter's lowest 16 bits. Register 15 holds the promiscuous flag in bit 15. Unlisted bits and registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_port | input | 1 | Port select: 1 address port, 0 data port |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data of the selected port |
| ev_init_done | input | 1 | Init completed event |
| ev_tx_done | input | 1 | Transmit completed event |
| ev_rx_done | input | 1 | Receive completed event |
| ev_mem_err | input | 1 | Memory error event |
| ev_missed | input | 1 | Missed frame event |
| ev_carrier_err | input | 1 | Carrier error event |
| ev_babble | input | 1 | Babble event |
| tx_active | input | 1 | Transmit engine running |
| rx_active | input | 1 | Receive engine running |
| irq | output | 1 | Gated interrupt request |
| init_pulse | output | 1 | Init strobe |
| start_pulse | output | 1 | Start strobe |
| stop_pulse | output | 1 | Stop strobe |
| demand_pulse | output | 1 | Transmit demand strobe |
| init_addr | output | 24 | Init block address |
| byte_ctl | output | 3 | Byte-order control bits |
| mcast_filter | output | 64 | Multicast filter |
| promisc | output | 1 | Promiscuous enable |

## Verification
An engine event and a host write-one-to-clear can hit the same flag in the same cycle. The bench provokes this by raising an event input on the same clock edge that captures a register 0 write clearing that same flag. It then expects the flag to read back set. A stop write that lands in the same cycle as events is judged the other way: there the stop must win and the flags must read back clear.

// File: rtl/netcsr_pkg.sv
`timescale 1ns/1ps
package netcsr_pkg;
    localparam int WORD_W    = 16;
    localparam int NUM_FLAGS = 7;
    localparam int FLAG_LSB  = 8;

    // control bit positions in register 0
    localparam int C_INIT = 0;
    localparam int C_STRT = 1;
    localparam int C_STOP = 2;
    localparam int C_TDMD = 3;
    localparam int C_TXON = 4;
    localparam int C_RXON = 5;
    localparam int C_INEA = 6;
    localparam int C_INTR = 7;
    localparam int C_ERR  = 15;

    // flag order inside the flag vector (bit FLAG_LSB + index in register 0)
    localparam int F_IDONE   = 0;
    localparam int F_TXDONE  = 1;
    localparam int F_RXDONE  = 2;
    localparam int F_MEMERR  = 3;
    localparam int F_MISSED  = 4;
    localparam int F_CARRIER = 5;
    localparam int F_BABBLE  = 6;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    // flags feeding the interrupt summary: all except carrier error
    localparam flag_vec_t INTR_MASK = 7'b101_1111;
    // flags feeding the error summary: memory, missed, carrier, babble
    localparam flag_vec_t ERR_MASK  = 7'b111_1000;

    typedef struct packed {
        logic      init;
        logic      strt;
        logic      stop;
        logic      tdmd;
        logic      inea;
        flag_vec_t flags;
        logic      p_init;
        logic      p_strt;
        logic      p_stop;
        logic      p_dmd;
    } main_state_t;
endpackage

// File: rtl/netcsr_sel.sv
`timescale 1ns/1ps
module netcsr_sel #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_addr,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel_q,
    output logic [15:0]      sel_word
);
    logic [SEL_W-1:0] sel_d;

    always_comb begin
        sel_d = sel_q;
        if (wr_addr) sel_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    always_comb begin
        sel_word = '0;
        sel_word[SEL_W-1:0] = sel_q;
    end
endmodule

// File: rtl/netcsr_main.sv
`timescale 1ns/1ps
module netcsr_main
    import netcsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_main,
    input  logic [15:0] wdata,
    input  flag_vec_t   ev,
    input  logic        tx_active,
    input  logic        rx_active,
    output logic [15:0] main_word,
    output logic        stopped,
    output logic        stop_hit,
    output logic        irq,
    output logic        init_pulse,
    output logic        start_pulse,
    output logic        stop_pulse,
    output logic        demand_pulse
);
    main_state_t st_d, st_q;
    flag_vec_t   clr_mask;
    flag_vec_t   ev_taken;
    logic        intr_sum;
    logic        err_sum;
    logic        unused_ro_bits;

    assign stop_hit       = wr_main & wdata[C_STOP];
    assign unused_ro_bits = ^{wdata[C_TXON], wdata[C_RXON], wdata[C_INTR], wdata[C_ERR]};

    always_comb begin
        st_d        = st_q;
        st_d.p_init = 1'b0;
        st_d.p_strt = 1'b0;
        st_d.p_stop = 1'b0;
        st_d.p_dmd  = 1'b0;
        clr_mask    = wr_main ? wdata[FLAG_LSB +: NUM_FLAGS] : '0;
        ev_taken    = st_q.stop ? '0 : ev;

        if (wr_main) st_d.inea = wdata[C_INEA];

        if (stop_hit) begin
            st_d.stop   = 1'b1;
            st_d.init   = 1'b0;
            st_d.strt   = 1'b0;
            st_d.tdmd   = 1'b0;
            st_d.flags  = '0;
            st_d.p_stop = 1'b1;
        end else begin
            st_d.flags = (st_q.flags & ~clr_mask) | ev_taken;
            if (ev_taken[F_TXDONE]) st_d.tdmd = 1'b0;
            if (wr_main && wdata[C_INIT]) begin
                st_d.init   = 1'b1;
                st_d.stop   = 1'b0;
                st_d.p_init = 1'b1;
            end
            if (wr_main && wdata[C_STRT]) begin
                st_d.strt   = 1'b1;
                st_d.stop   = 1'b0;
                st_d.p_strt = 1'b1;
            end
            if (wr_main && wdata[C_TDMD] && !st_d.stop) begin
                st_d.tdmd  = 1'b1;
                st_d.p_dmd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.stop <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign intr_sum = |(st_q.flags & INTR_MASK);
    assign err_sum  = |(st_q.flags & ERR_MASK);

    always_comb begin
        main_word                        = '0;
        main_word[C_INIT]                = st_q.init;
        main_word[C_STRT]                = st_q.strt;
        main_word[C_STOP]                = st_q.stop;
        main_word[C_TDMD]                = st_q.tdmd;
        main_word[C_TXON]                = st_q.strt & tx_active;
        main_word[C_RXON]                = st_q.strt & rx_active;
        main_word[C_INEA]                = st_q.inea;
        main_word[C_INTR]                = intr_sum;
        main_word[FLAG_LSB +: NUM_FLAGS] = st_q.flags;
        main_word[C_ERR]                 = err_sum;
    end

    assign stopped      = st_q.stop;
    assign irq          = intr_sum & st_q.inea;
    assign init_pulse   = st_q.p_init;
    assign start_pulse  = st_q.p_strt;
    assign stop_pulse   = st_q.p_stop;
    assign demand_pulse = st_q.p_dmd;
endmodule

// File: rtl/netcsr_cfg.sv
`timescale 1ns/1ps
module netcsr_cfg #(
    parameter int SEL_W     = 4,
    parameter int ADDR_HI_W = 8,
    parameter int FILT_W    = 64,
    parameter int FILT_BASE = 8,
    parameter int MODE_REG  = 15,
    parameter int ADDR_LO_REG = 1,
    parameter int ADDR_HI_REG = 2,
    parameter int BCTL_REG    = 3,
    parameter int BCTL_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_cfg,
    input  logic [SEL_W-1:0]        sel,
    input  logic [15:0]             wdata,
    input  logic                    stopped,
    input  logic                    stop_hit,
    output logic [15:0]             rd_word,
    output logic [16+ADDR_HI_W-1:0] init_addr,
    output logic [BCTL_W-1:0]       byte_ctl,
    output logic [FILT_W-1:0]       mcast_filter,
    output logic                    promisc
);
    localparam int FILT_WORDS = FILT_W / 16;

    typedef struct packed {
        logic [15:0]          alo;
        logic [ADDR_HI_W-1:0] ahi;
        logic [BCTL_W-1:0]    bctl;
        logic                 prom;
    } cfg_state_t;

    cfg_state_t c_d, c_q;
    logic       wr_ok;

    assign wr_ok = wr_cfg & stopped;

    always_comb begin
        c_d = c_q;
        if (wr_ok) begin
            if (sel == SEL_W'(ADDR_LO_REG)) c_d.alo  = wdata;
            if (sel == SEL_W'(ADDR_HI_REG)) c_d.ahi  = wdata[ADDR_HI_W-1:0];
            if (sel == SEL_W'(BCTL_REG))    c_d.bctl = wdata[BCTL_W-1:0];
            if (sel == SEL_W'(MODE_REG))    c_d.prom = wdata[15];
        end
        if (stop_hit) c_d.bctl = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    for (genvar gi = 0; gi < FILT_WORDS; gi++) begin : g_filt
        logic [15:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (wr_ok && sel == SEL_W'(FILT_BASE + gi)) w_d = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) w_q <= '0;
            else        w_q <= w_d;
        end

        assign mcast_filter[gi*16 +: 16] = w_q;
    end

    always_comb begin
        rd_word = '0;
        if (sel == SEL_W'(ADDR_LO_REG)) rd_word = c_q.alo;
        if (sel == SEL_W'(ADDR_HI_REG)) rd_word[ADDR_HI_W-1:0] = c_q.ahi;
        if (sel == SEL_W'(BCTL_REG))    rd_word[BCTL_W-1:0] = c_q.bctl;
        if (sel == SEL_W'(MODE_REG))    rd_word[15] = c_q.prom;
        for (int i = 0; i < FILT_WORDS; i++) begin
            if (sel == SEL_W'(FILT_BASE + i)) rd_word = mcast_filter[i*16 +: 16];
        end
    end

    assign init_addr = {c_q.ahi, c_q.alo};
    assign byte_ctl  = c_q.bctl;
    assign promisc   = c_q.prom;
endmodule

// File: rtl/netcsr_regs.sv
`timescale 1ns/1ps
module netcsr_regs
    import netcsr_pkg::*;
#(
    parameter int SEL_W     = 4,
    parameter int ADDR_HI_W = 8,
    parameter int FILT_W    = 64,
    parameter int FILT_BASE = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_port,
    input  logic [15:0]             bus_wdata,
    output logic [15:0]             bus_rdata,
    input  logic                    ev_init_done,
    input  logic                    ev_tx_done,
    input  logic                    ev_rx_done,
    input  logic                    ev_mem_err,
    input  logic                    ev_missed,
    input  logic                    ev_carrier_err,
    input  logic                    ev_babble,
    input  logic                    tx_active,
    input  logic                    rx_active,
    output logic                    irq,
    output logic                    init_pulse,
    output logic                    start_pulse,
    output logic                    stop_pulse,
    output logic                    demand_pulse,
    output logic [16+ADDR_HI_W-1:0] init_addr,
    output logic [2:0]              byte_ctl,
    output logic [FILT_W-1:0]       mcast_filter,
    output logic                    promisc
);
    localparam int MODE_REG = (1 << SEL_W) - 1;

    logic [SEL_W-1:0] sel_q;
    logic [15:0]      sel_word;
    logic [15:0]      main_word;
    logic [15:0]      cfg_word;
    logic             stopped;
    logic             stop_hit;
    logic             wr_addr, wr_main, wr_cfg;
    flag_vec_t        ev_vec;

    assign wr_addr = bus_wr & bus_port;
    assign wr_main = bus_wr & ~bus_port & (sel_q == '0);
    assign wr_cfg  = bus_wr & ~bus_port & (sel_q != '0);

    always_comb begin
        ev_vec            = '0;
        ev_vec[F_IDONE]   = ev_init_done;
        ev_vec[F_TXDONE]  = ev_tx_done;
        ev_vec[F_RXDONE]  = ev_rx_done;
        ev_vec[F_MEMERR]  = ev_mem_err;
        ev_vec[F_MISSED]  = ev_missed;
        ev_vec[F_CARRIER] = ev_carrier_err;
        ev_vec[F_BABBLE]  = ev_babble;
    end

    netcsr_sel #(.SEL_W(SEL_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_addr  (wr_addr),
        .wdata    (bus_wdata[SEL_W-1:0]),
        .sel_q    (sel_q),
        .sel_word (sel_word)
    );

    netcsr_main u_main (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_main      (wr_main),
        .wdata        (bus_wdata),
        .ev           (ev_vec),
        .tx_active    (tx_active),
        .rx_active    (rx_active),
        .main_word    (main_word),
        .stopped      (stopped),
        .stop_hit     (stop_hit),
        .irq          (irq),
        .init_pulse   (init_pulse),
        .start_pulse  (start_pulse),
        .stop_pulse   (stop_pulse),
        .demand_pulse (demand_pulse)
    );

    netcsr_cfg #(
        .SEL_W     (SEL_W),
        .ADDR_HI_W (ADDR_HI_W),
        .FILT_W    (FILT_W),
        .FILT_BASE (FILT_BASE),
        .MODE_REG  (MODE_REG)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_cfg       (wr_cfg),
        .sel          (sel_q),
        .wdata        (bus_wdata),
        .stopped      (stopped),
        .stop_hit     (stop_hit),
        .rd_word      (cfg_word),
        .init_addr    (init_addr),
        .byte_ctl     (byte_ctl),
        .mcast_filter (mcast_filter),
        .promisc      (promisc)
    );

    assign bus_rdata = bus_port ? sel_word : ((sel_q == '0) ? main_word : cfg_word);
endmodule

// File: rtl/netcsr_regs_chk.sv
`timescale 1ns/1ps
module netcsr_regs_chk #(
    parameter int SEL_W     = 4,
    parameter int ADDR_HI_W = 8,
    parameter int FILT_W    = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic                    bus_port,
    input logic [15:0]             bus_wdata,
    input logic [SEL_W-1:0]        sel_q,
    input logic [15:0]             main_word,
    input logic                    ev_rx_done,
    input logic                    irq,
    input logic                    init_pulse,
    input logic [16+ADDR_HI_W-1:0] init_addr,
    input logic [2:0]              byte_ctl,
    input logic [FILT_W-1:0]       mcast_filter,
    input logic                    promisc
);
    logic stop_wr;
    logic main_wr;
    assign main_wr = bus_wr && !bus_port && (sel_q == '0);
    assign stop_wr = main_wr && bus_wdata[2];

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_port) |=> $stable(sel_q));

    assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (main_word[5:0] == 6'b000100) && (main_word[14:8] == 7'd0));

    assert_swap_default_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> byte_ctl == 3'd0);

    assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_port && sel_q != '0 && !main_word[2])
        |=> ($stable(init_addr) && $stable(byte_ctl) && $stable(mcast_filter) && $stable(promisc)));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (main_word[6] && main_word[7]));

    assert_err_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_word[11]) |-> main_word[15]);

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_done && !main_word[2] && !stop_wr) |=> main_word[10]);
endmodule

bind netcsr_regs netcsr_regs_chk #(
    .SEL_W     (SEL_W),
    .ADDR_HI_W (ADDR_HI_W),
    .FILT_W    (FILT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_port     (bus_port),
    .bus_wdata    (bus_wdata),
    .sel_q        (sel_q),
    .main_word    (main_word),
    .ev_rx_done   (ev_rx_done),
    .irq          (irq),
    .init_pulse   (init_pulse),
    .init_addr    (init_addr),
    .byte_ctl     (byte_ctl),
    .mcast_filter (mcast_filter),
    .promisc      (promisc)
);

// File: tb/tb_netcsr_regs.sv
`timescale 1ns/1ps
module tb_netcsr_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_port = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ev_init_done = 1'b0, ev_tx_done = 1'b0, ev_rx_done = 1'b0;
    logic        ev_mem_err = 1'b0, ev_missed = 1'b0, ev_carrier_err = 1'b0, ev_babble = 1'b0;
    logic        tx_active = 1'b0, rx_active = 1'b0;
    logic        irq, init_pulse, start_pulse, stop_pulse, demand_pulse;
    logic [23:0] init_addr;
    logic [2:0]  byte_ctl;
    logic [63:0] mcast_filter;
    logic        promisc;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic done    = 1'b0;
    logic [15:0] v;

    always #2 clk = ~clk;

    netcsr_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_port(bus_port),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_init_done(ev_init_done), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
        .ev_mem_err(ev_mem_err), .ev_missed(ev_missed), .ev_carrier_err(ev_carrier_err),
        .ev_babble(ev_babble), .tx_active(tx_active), .rx_active(rx_active),
        .irq(irq), .init_pulse(init_pulse), .start_pulse(start_pulse),
        .stop_pulse(stop_pulse), .demand_pulse(demand_pulse),
        .init_addr(init_addr), .byte_ctl(byte_ctl), .mcast_filter(mcast_filter),
        .promisc(promisc)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic port, input logic [15:0] d);
        @(negedge clk);
        bus_port  = port;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic port, output logic [15:0] d);
        bus_port = port;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_ev(input logic [6:0] m);
        {ev_babble, ev_carrier_err, ev_missed, ev_mem_err,
         ev_rx_done, ev_tx_done, ev_init_done} = m;
    endtask

    task automatic ev_pulse(input logic [6:0] m);
        @(negedge clk);
        set_ev(m);
        @(negedge clk);
        set_ev(7'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 reg0 reset", v, 16'h0004);
        rd(1, v); chk("R1 addr port reset", v, 16'h0000);
        chk("R1 irq and strobes", {irq, init_pulse, start_pulse, stop_pulse, demand_pulse}, 5'd0);
        chk("R1 outputs", {init_addr, byte_ctl, promisc}, 28'd0);

        // R3 init plus stop while stopped
        wr(0, 16'h0005);
        chk("R3 no init strobe", init_pulse, 1'b0);
        chk("R3 stop strobe", stop_pulse, 1'b1);
        rd(0, v); chk("R3 readback", v, 16'h0004);

        // R13 and R11: configuration while stopped
        wr(1, 16'h0001); wr(0, 16'hBEEF);
        wr(1, 16'h0002); wr(0, 16'hA5C3);
        rd(0, v); chk("R13 high address bits", v, 16'h00C3);
        chk("R13 init address", init_addr, 24'hC3BEEF);
        wr(1, 16'h0003); wr(0, 16'h00FF);
        rd(0, v); chk("R13 byte control", v, 16'h0007);
        rd(0, v); chk("R2 repeated read", v, 16'h0007);
        rd(1, v); chk("R2 address readback", v, 16'h0003);
        for (int i = 0; i < 4; i++) begin
            wr(1, 16'(8 + i));
            wr(0, 16'h1111 * 16'(i + 1));
        end
        chk("R13 filter order", mcast_filter, 64'h4444_3333_2222_1111);
        wr(1, 16'h0009); rd(0, v); chk("R13 filter word 1", v, 16'h2222);
        wr(1, 16'h000F); wr(0, 16'hFFFF);
        rd(0, v); chk("R13 mode register", v, 16'h8000);
        chk("R13 promisc", promisc, 1'b1);
        wr(1, 16'h0004); wr(0, 16'hFFFF);
        rd(0, v); chk("R13 unmapped register", v, 16'h0000);

        // R4 start
        wr(1, 16'h0000);
        wr(0, 16'h0042);
        chk("R4 start strobe", start_pulse, 1'b1);
        @(negedge clk);
        chk("R4 start strobe one cycle", start_pulse, 1'b0);
        rd(0, v); chk("R4 running", v, 16'h0042);
        chk("R12 byte control kept while running", byte_ctl, 3'd7);

        // R11 writes ignored while running
        wr(1, 16'h0001); wr(0, 16'h1234);
        rd(0, v); chk("R11 address low locked", v, 16'hBEEF);
        wr(1, 16'h0003); wr(0, 16'h0000);
        rd(0, v); chk("R11 byte control locked", v, 16'h0007);
        wr(1, 16'h000A); wr(0, 16'h0000);
        chk("R11 filter locked", mcast_filter, 64'h4444_3333_2222_1111);
        wr(1, 16'h000F); wr(0, 16'h0000);
        chk("R11 promisc locked", promisc, 1'b1);
        chk("R11 address locked", init_addr, 24'hC3BEEF);

        // R5 read-only activity bits
        wr(1, 16'h0000);
        tx_active = 1'b1; rd(0, v); chk("R5 transmit active", v, 16'h0052);
        rx_active = 1'b1; rd(0, v); chk("R5 receive active", v, 16'h0072);
        tx_active = 1'b0; rx_active = 1'b0;
        wr(0, 16'h00F2);
        rd(0, v); chk("R5 read-only bits ignore writes", v, 16'h0042);

        // R6 R7 R8 sweep of clear masks with interrupt enable on and off
        for (int ie = 0; ie < 2; ie++) begin
            for (int m = 0; m < 128; m++) begin
                logic [6:0]  fl;
                logic [15:0] e;
                ev_pulse(7'h7F);
                wr(0, {1'(m % 2), 7'(m), 1'b0, 1'(ie), 6'b000010});
                fl = 7'h7F & ~7'(m);
                e  = {|(fl & 7'h78), fl, |(fl & 7'h5F), 1'(ie), 6'b000010};
                rd(0, v);
                chk("R6 R7 clear sweep", v, e);
                chk("R8 interrupt gate", irq, (|(fl & 7'h5F)) & 1'(ie));
            end
        end

        // R9 event and clear of the same flag in one cycle
        @(negedge clk);
        bus_port = 1'b0; bus_wdata = 16'h0442; bus_wr = 1'b1; ev_rx_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_rx_done = 1'b0;
        rd(0, v); chk("R9 event wins over clear", v, 16'h04C2);
        wr(0, 16'h0442);
        rd(0, v); chk("R6 later clear", v, 16'h0042);

        // R4 demand
        wr(0, 16'h004A);
        chk("R4 demand strobe", demand_pulse, 1'b1);
        rd(0, v); chk("R4 demand set", v, 16'h004A);
        wr(0, 16'h0042);
        rd(0, v); chk("R4 writing zero keeps demand", v, 16'h004A);
        ev_pulse(7'h02);
        rd(0, v); chk("R4 demand cleared by transmit done", v, 16'h02C2);
        wr(0, 16'h0242);
        wr(0, 16'h0041);
        chk("R4 init strobe", init_pulse, 1'b1);
        rd(0, v); chk("R4 init bit", v, 16'h0043);

        // R10 R12 stop with events in the same cycle, then events while stopped
        @(negedge clk);
        bus_port = 1'b0; bus_wdata = 16'h0004; bus_wr = 1'b1; set_ev(7'h7F);
        @(negedge clk);
        bus_wr = 1'b0; set_ev(7'd0);
        chk("R10 stop strobe", stop_pulse, 1'b1);
        rd(0, v); chk("R10 stop clears", v, 16'h0004);
        chk("R12 byte control default", byte_ctl, 3'd0);
        ev_pulse(7'h7F);
        rd(0, v); chk("R10 events ignored while stopped", v, 16'h0004);
        chk("R10 no interrupt while stopped", irq, 1'b0);
        wr(1, 16'h0003); wr(0, 16'h0004);
        rd(0, v); chk("R11 writable again when stopped", v, 16'h0004);
        wr(1, 16'h0000);
        wr(0, 16'h0004);
        chk("R12 stop resets byte control again", byte_ctl, 3'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule